// File: doc/BRIEF.md
# Per-Cycle Power Measurement Engine

This block turns a stream of filtered sample vectors into per-cycle electrical measurements. Each sample strobe delivers one signed sample for each of eight channels. Over one electrical cycle of N samples (64 or 128, picked by one configuration bit), the engine builds four running sums. For every channel it keeps the sum of samples and the sum of their squares. For every configured voltage/current pair it keeps the sum of v·i and the sum of v times the current sample taken 3N/4 samples earlier.

One multiplier and one set of adders serve all channels and pairs in turn. A sequencer walks through them between strobes. When the last sample of a cycle has been folded in, the sequencer converts the sums into results: DC offset, RMS (through a bit-serial square root), real power and reactive power. Offset removal can optionally be applied to the power terms. The results are published together with a one-cycle done pulse and held until the next cycle completes.

Top module: `cycle_power_engine`

## Requirements
- R1: `long_cyc`=0 selects N=64 and `long_cyc`=1 selects N=128 samples per electrical cycle. `res_done` pulses once for every N accepted strobes, and a change of `long_cyc` seen at an accepted strobe restarts counting with that strobe as sample 0.
- R2: For each channel c, `dc_bus[c*16 +: 16]` equals the sum of that channel's N samples, arithmetically shifted right by log2(N), which is floor division.
- R3: For each channel c, `rms_bus[c*16 +: 16]` is unsigned. It equals floor(sqrt(m)), where m = (sum of squares >>> log2 N) − DC², and it is 0 when m is negative.
- R4: Pair p uses `pair_sel[6p+2:6p]` as its voltage channel and `pair_sel[6p+5:6p+3]` as its current channel. With `dc_strip`=0, `pwr_p_bus[34p +: 34]` (signed) equals (sum of v[k]·i[k]) >>> log2 N.
- R5: With `dc_strip`=0, `pwr_q_bus[34p +: 34]` equals (sum of v[k]·i[k−3N/4]) >>> log2 N. Current samples from before the latest reset or change of N count as zero.
- R6: With `dc_strip`=1, both power results of a pair have DC_v·DC_i of the same cycle subtracted.
- R7: `res_valid` is published with each done pulse. It is 0 for the first cycle after reset or after a change of N, and 1 for every later cycle.
- R8: `res_done` lasts one clock. All result outputs and `res_valid` change only in a clock where `res_done` is high.
- R9: A strobe that arrives while the sequencer is busy is dropped and sets `overrun`, which stays set until reset.
- R10: After reset, all result buses are zero and `res_done`, `res_valid` and `overrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | One-clock sample strobe |
| smp_bus | input | 128 | Eight signed 16-bit samples, channel c at bits [16c+15:16c] |
| long_cyc | input | 1 | Cycle length select: 0 gives 64 samples, 1 gives 128 |
| pair_sel | input | 18 | Three pairs of 3-bit channel indices (voltage low, current high) |
| dc_strip | input | 1 | Subtract DC_v·DC_i from the power results |
| res_done | output | 1 | One-clock pulse when new results are published |
| res_valid | output | 1 | Published results come from a complete cycle |
| dc_bus | output | 128 | Per-channel signed DC offset |
| rms_bus | output | 128 | Per-channel unsigned RMS |
| pwr_p_bus | output | 102 | Per-pair signed real power, 34 bits each |
| pwr_q_bus | output | 102 | Per-pair signed reactive power, 34 bits each |
| overrun | output | 1 | Sticky flag: a strobe arrived while busy |

## Verification
A new sample strobe can coincide with a sequencer that is still folding in the previous sample. It can also coincide with the cycle-end conversion. The bench provokes this by sending a second strobe a few clocks after an accepted one. It then judges that `overrun` rises and stays set, that no extra done pulse appears, and that the held results stay unchanged. The other collision comes when a change of N is seen on the same strobe that must become sample 0. Here the bench checks, against its own model, that the next cycle's results are flagged invalid and that reactive power treats older current samples as zero.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CHAN,
      ST_PAIR,
      ST_FDC,
      ST_FSQ,
      ST_FPW,
      ST_DONE
   } seq_st_t;
endpackage

// File: rtl/pwr_delay_line.sv
module pwr_delay_line #(
   parameter int W     = 16,
   parameter int DEPTH = 128,
   localparam int AWD  = $clog2(DEPTH)
) (
   input  logic           clk,
   input  logic           we,
   input  logic [AWD-1:0] waddr,
   input  logic [W-1:0]   wdata,
   input  logic [AWD-1:0] raddr,
   output logic [W-1:0]   rdata
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/pwr_isqrt.sv
module pwr_isqrt #(
   parameter int W = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           go,
   input  logic [2*W-1:0] arg,
   output logic           done,
   output logic [W-1:0]   root
);
   localparam int RW = W + 3;
   localparam int CNW = $clog2(W + 1);

   logic [2*W-1:0] a_sh, arg_q;
   logic [RW-1:0]  rem, rem_n, trial;
   logic [CNW-1:0] cnt;
   logic           busy;

   assign rem_n = {rem[RW-3:0], a_sh[2*W-1 -: 2]};
   assign trial = RW'({root, 2'b01});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_sh  <= '0;
         arg_q <= '0;
         rem   <= '0;
         root  <= '0;
         cnt   <= '0;
         busy  <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (go) begin
            a_sh  <= arg;
            arg_q <= arg;
            rem   <= '0;
            root  <= '0;
            cnt   <= CNW'(W);
            busy  <= 1'b1;
         end else if (busy) begin
            a_sh <= {a_sh[2*W-3:0], 2'b00};
            if (rem_n >= trial) begin
               rem  <= rem_n - trial;
               root <= {root[W-2:0], 1'b1};
            end else begin
               rem  <= rem_n;
               root <= {root[W-2:0], 1'b0};
            end
            cnt <= cnt - CNW'(1);
            if (cnt == CNW'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   logic [2*W+1:0] r_sq, r1_sq;
   assign r_sq  = (2*W+2)'(root) * (2*W+2)'(root);
   assign r1_sq = ((2*W+2)'(root) + 1) * ((2*W+2)'(root) + 1);

   // R3
   sqrt_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (r_sq <= (2*W+2)'(arg_q)) && (r1_sq > (2*W+2)'(arg_q)));
endmodule

// File: rtl/cycle_power_engine.sv
module cycle_power_engine
   import pwr_pkg::*;
#(
   parameter int NCH     = 8,
   parameter int W       = 16,
   parameter int NPAIR   = 3,
   parameter int LOG_NLO = 6,
   localparam int CHW    = $clog2(NCH),
   localparam int PW     = 2*W + 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     smp_stb,
   input  logic [NCH*W-1:0]         smp_bus,
   input  logic                     long_cyc,
   input  logic [NPAIR*2*CHW-1:0]   pair_sel,
   input  logic                     dc_strip,
   output logic                     res_done,
   output logic                     res_valid,
   output logic [NCH*W-1:0]         dc_bus,
   output logic [NCH*W-1:0]         rms_bus,
   output logic [NPAIR*PW-1:0]      pwr_p_bus,
   output logic [NPAIR*PW-1:0]      pwr_q_bus,
   output logic                     overrun
);
   localparam int LOG_NHI = LOG_NLO + 1;
   localparam int NMAX    = 1 << LOG_NHI;
   localparam int CW      = LOG_NHI;
   localparam int AW      = 2*W + LOG_NHI;
   localparam int PIW     = (NPAIR > 1) ? $clog2(NPAIR) : 1;

   initial begin
      assert (NCH >= 2 && (NCH & (NCH - 1)) == 0) else $error("NCH must be a power of two");
      assert (W >= 4) else $error("W too small");
      assert (LOG_NLO >= 2) else $error("LOG_NLO too small");
      assert (NPAIR >= 1) else $error("NPAIR must be at least one");
   end

   seq_st_t st;
   logic [CHW-1:0]  ci;
   logic [PIW-1:0]  pi;
   logic            ph;
   logic [CW-1:0]   ncnt;
   logic            n_act, first_cyc;

   logic signed [W-1:0]  smp_r [NCH];
   logic signed [AW-1:0] acc_s [NCH];
   logic signed [AW-1:0] acc_sq [NCH];
   logic signed [AW-1:0] acc_p [NPAIR];
   logic signed [AW-1:0] acc_q [NPAIR];
   logic signed [W-1:0]  dc_w [NCH];
   logic [W-1:0]         rms_w [NCH];
   logic signed [PW-1:0] p_w [NPAIR];
   logic signed [PW-1:0] q_w [NPAIR];
   logic signed [W-1:0]  dc_o [NCH];
   logic [W-1:0]         rms_o [NCH];
   logic signed [PW-1:0] p_o [NPAIR];
   logic signed [PW-1:0] q_o [NPAIR];

   // cycle geometry from the active length
   logic [CW-1:0] nlast, qtr, three_q, rd_ptr, nmask;
   int unsigned   sh;
   assign nlast   = CW'(n_act ? NMAX - 1 : NMAX/2 - 1);
   assign nmask   = nlast;
   assign qtr     = CW'(n_act ? NMAX/4 : NMAX/8);
   assign three_q = CW'(n_act ? 3*NMAX/4 : 3*NMAX/8);
   assign sh      = n_act ? LOG_NHI : LOG_NLO;
   assign rd_ptr  = (ncnt + qtr) & nmask;

   // pair channel decode
   logic [CHW-1:0] v_idx, i_idx;
   assign v_idx = pair_sel[int'(pi)*2*CHW +: CHW];
   assign i_idx = pair_sel[int'(pi)*2*CHW + CHW +: CHW];

   // per-pair circular buffers holding the current samples of one cycle
   logic [W-1:0] dl_rd [NPAIR];
   generate
      for (genvar g = 0; g < NPAIR; g++) begin : g_dly
         pwr_delay_line #(.W(W), .DEPTH(NMAX)) u_dly (
            .clk   (clk),
            .we    (st == ST_PAIR && ph && pi == PIW'(g)),
            .waddr (ncnt),
            .wdata (smp_r[i_idx]),
            .raddr (rd_ptr),
            .rdata (dl_rd[g])
         );
      end
   endgenerate

   logic signed [W-1:0] dly_op;
   assign dly_op = (first_cyc && ncnt < three_q) ? '0 : $signed(dl_rd[pi]);

   // the single shared multiplier and its operand selection
   logic signed [W-1:0]   dc_now;
   logic signed [W-1:0]   op_a, op_b;
   logic signed [2*W-1:0] prod;
   assign dc_now = W'(acc_s[ci] >>> sh);

   always_comb begin
      op_a = '0;
      op_b = '0;
      case (st)
         ST_CHAN: begin op_a = smp_r[ci];     op_b = smp_r[ci]; end
         ST_PAIR: begin op_a = smp_r[v_idx];  op_b = ph ? dly_op : smp_r[i_idx]; end
         ST_FDC:  begin op_a = dc_now;        op_b = dc_now; end
         ST_FPW:  begin op_a = dc_w[v_idx];   op_b = dc_w[i_idx]; end
         default: ;
      endcase
   end
   assign prod = op_a * op_b;

   // cycle-end conversion
   logic signed [AW:0]   ms;
   logic [2*W-1:0]       sq_arg;
   logic signed [AW-1:0] pm_src;
   logic signed [PW-1:0] fin_val;
   logic                 sq_done;
   logic [W-1:0]         sq_root;

   assign ms      = (AW+1)'(acc_sq[ci] >>> sh) - (AW+1)'(prod);
   assign sq_arg  = (ms < 0) ? '0 : (2*W)'(ms);
   assign pm_src  = ph ? acc_q[pi] : acc_p[pi];
   assign fin_val = PW'(pm_src >>> sh) - (dc_strip ? PW'(prod) : '0);

   pwr_isqrt #(.W(W)) u_sqrt (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (st == ST_FDC),
      .arg   (sq_arg),
      .done  (sq_done),
      .root  (sq_root)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         ci        <= '0;
         pi        <= '0;
         ph        <= 1'b0;
         ncnt      <= '0;
         n_act     <= 1'b0;
         first_cyc <= 1'b1;
         res_done  <= 1'b0;
         res_valid <= 1'b0;
         overrun   <= 1'b0;
         for (int c = 0; c < NCH; c++) begin
            smp_r[c]  <= '0;
            acc_s[c]  <= '0;
            acc_sq[c] <= '0;
            dc_w[c]   <= '0;
            rms_w[c]  <= '0;
            dc_o[c]   <= '0;
            rms_o[c]  <= '0;
         end
         for (int p = 0; p < NPAIR; p++) begin
            acc_p[p] <= '0;
            acc_q[p] <= '0;
            p_w[p]   <= '0;
            q_w[p]   <= '0;
            p_o[p]   <= '0;
            q_o[p]   <= '0;
         end
      end else begin
         res_done <= 1'b0;
         if (smp_stb && st != ST_IDLE) overrun <= 1'b1;
         case (st)
            ST_IDLE: if (smp_stb) begin
               for (int c = 0; c < NCH; c++) smp_r[c] <= smp_bus[c*W +: W];
               ci <= '0;
               pi <= '0;
               ph <= 1'b0;
               st <= ST_CHAN;
               if (long_cyc != n_act) begin
                  n_act     <= long_cyc;
                  ncnt      <= '0;
                  first_cyc <= 1'b1;
                  for (int c = 0; c < NCH; c++) begin
                     acc_s[c]  <= '0;
                     acc_sq[c] <= '0;
                  end
                  for (int p = 0; p < NPAIR; p++) begin
                     acc_p[p] <= '0;
                     acc_q[p] <= '0;
                  end
               end
            end
            ST_CHAN: begin
               acc_s[ci]  <= acc_s[ci] + AW'(smp_r[ci]);
               acc_sq[ci] <= acc_sq[ci] + AW'(prod);
               if (ci == CHW'(NCH - 1)) begin
                  ci <= '0;
                  st <= ST_PAIR;
               end else begin
                  ci <= ci + CHW'(1);
               end
            end
            ST_PAIR: begin
               if (!ph) begin
                  acc_p[pi] <= acc_p[pi] + AW'(prod);
                  ph        <= 1'b1;
               end else begin
                  acc_q[pi] <= acc_q[pi] + AW'(prod);
                  ph        <= 1'b0;
                  if (pi == PIW'(NPAIR - 1)) begin
                     pi <= '0;
                     if (ncnt == nlast) begin
                        st <= ST_FDC;
                     end else begin
                        ncnt <= ncnt + CW'(1);
                        st   <= ST_IDLE;
                     end
                  end else begin
                     pi <= pi + PIW'(1);
                  end
               end
            end
            ST_FDC: begin
               dc_w[ci] <= dc_now;
               st       <= ST_FSQ;
            end
            ST_FSQ: if (sq_done) begin
               rms_w[ci] <= sq_root;
               if (ci == CHW'(NCH - 1)) begin
                  ci <= '0;
                  ph <= 1'b0;
                  st <= ST_FPW;
               end else begin
                  ci <= ci + CHW'(1);
                  st <= ST_FDC;
               end
            end
            ST_FPW: begin
               if (!ph) begin
                  p_w[pi] <= fin_val;
                  ph      <= 1'b1;
               end else begin
                  q_w[pi] <= fin_val;
                  ph      <= 1'b0;
                  if (pi == PIW'(NPAIR - 1)) begin
                     pi <= '0;
                     st <= ST_DONE;
                  end else begin
                     pi <= pi + PIW'(1);
                  end
               end
            end
            ST_DONE: begin
               for (int c = 0; c < NCH; c++) begin
                  dc_o[c]   <= dc_w[c];
                  rms_o[c]  <= rms_w[c];
                  acc_s[c]  <= '0;
                  acc_sq[c] <= '0;
               end
               for (int p = 0; p < NPAIR; p++) begin
                  p_o[p]   <= p_w[p];
                  q_o[p]   <= q_w[p];
                  acc_p[p] <= '0;
                  acc_q[p] <= '0;
               end
               res_done  <= 1'b1;
               res_valid <= !first_cyc;
               first_cyc <= 1'b0;
               ncnt      <= '0;
               st        <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   generate
      for (genvar g = 0; g < NCH; g++) begin : g_chout
         assign dc_bus[g*W +: W]  = dc_o[g];
         assign rms_bus[g*W +: W] = rms_o[g];
      end
      for (genvar g = 0; g < NPAIR; g++) begin : g_prout
         assign pwr_p_bus[g*PW +: PW] = p_o[g];
         assign pwr_q_bus[g*PW +: PW] = q_o[g];
      end
   endgenerate

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_done |=> !res_done);
   // R8
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !res_done |-> $stable(dc_bus) && $stable(rms_bus) && $stable(pwr_p_bus)
                    && $stable(pwr_q_bus) && $stable(res_valid));
   // R9
   overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);
   // R1
   sample_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ncnt <= nlast);
endmodule

// File: tb/cycle_power_engine_test.sv
module cycle_power_engine_test;
   localparam int NCH = 8, W = 16, NPAIR = 3, PW = 2*W + 2, CHW = 3;
   localparam int PERIOD = 200;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic                   rst_n, smp_stb, long_cyc, dc_strip;
   logic [NCH*W-1:0]       smp_bus;
   logic [NPAIR*2*CHW-1:0] pair_sel;
   logic                   res_done, res_valid, overrun;
   logic [NCH*W-1:0]       dc_bus, rms_bus;
   logic [NPAIR*PW-1:0]    pwr_p_bus, pwr_q_bus;

   cycle_power_engine uut (
      .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_bus(smp_bus),
      .long_cyc(long_cyc), .pair_sel(pair_sel), .dc_strip(dc_strip),
      .res_done(res_done), .res_valid(res_valid), .dc_bus(dc_bus),
      .rms_bus(rms_bus), .pwr_p_bus(pwr_p_bus), .pwr_q_bus(pwr_q_bus),
      .overrun(overrun)
   );

   int vectors = 0, misses = 0, dones = 0;
   bit checking = 0, finished = 0;

   // reference model state
   longint stream [NCH][$];
   bit     m_long = 0, m_first = 1;
   int     m_k = 0;
   longint pe_dc [NCH], pe_rms [NCH], pe_p [NPAIR], pe_q [NPAIR];
   longint he_dc [NCH], he_rms [NCH], he_p [NPAIR], he_q [NPAIR];
   bit     pe_valid, he_valid = 0, pe_ac, pending = 0;

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      vectors++;
      if (act != exp) begin
         misses++;
         $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic longint fsqrt(input longint x);
      longint r = 0;
      for (int b = 16; b >= 0; b--)
         if ((r | (64'sd1 <<< b)) * (r | (64'sd1 <<< b)) <= x) r = r | (64'sd1 <<< b);
      return r;
   endfunction

   task automatic compute_expected();
      int nl = m_long ? 128 : 64;
      int sh = m_long ? 7 : 6;
      int base = m_k - nl;
      if (pending) begin
         misses++;
         $display("FAIL R1: done missing actual=0 expected=1");
      end
      for (int c = 0; c < NCH; c++) begin
         longint s = 0, sq = 0, ms;
         for (int n = 0; n < nl; n++) begin
            s  += stream[c][base+n];
            sq += stream[c][base+n] * stream[c][base+n];
         end
         pe_dc[c] = s >>> sh;
         ms = (sq >>> sh) - pe_dc[c] * pe_dc[c];
         pe_rms[c] = (ms < 0) ? 0 : fsqrt(ms);
      end
      for (int p = 0; p < NPAIR; p++) begin
         int vi = int'(pair_sel[p*2*CHW +: CHW]);
         int ii = int'(pair_sel[p*2*CHW + CHW +: CHW]);
         longint sp = 0, sqq = 0, corr;
         for (int n = 0; n < nl; n++) begin
            int k = base + n;
            longint d = (k >= 3*nl/4) ? stream[ii][k - 3*nl/4] : 0;
            sp  += stream[vi][k] * stream[ii][k];
            sqq += stream[vi][k] * d;
         end
         corr = dc_strip ? pe_dc[vi] * pe_dc[ii] : 0;
         pe_p[p] = (sp >>> sh) - corr;
         pe_q[p] = (sqq >>> sh) - corr;
      end
      pe_ac    = dc_strip;
      pe_valid = !m_first;
      m_first  = 0;
      pending  = 1;
   endtask

   task automatic strobe(input int v [NCH]);
      int nl;
      @(negedge clk);
      if (long_cyc != m_long) begin
         m_long  = long_cyc;
         m_k     = 0;
         m_first = 1;
         for (int c = 0; c < NCH; c++) stream[c].delete();
      end
      for (int c = 0; c < NCH; c++) begin
         smp_bus[c*W +: W] = W'(v[c]);
         stream[c].push_back(longint'(v[c]));
      end
      smp_stb = 1'b1;
      m_k++;
      nl = m_long ? 128 : 64;
      if (m_k % nl == 0) compute_expected();
      @(negedge clk);
      smp_stb = 1'b0;
      repeat (PERIOD - 2) @(negedge clk);
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && checking) begin
         if (res_done) begin
            if (!pending) begin
               misses++;
               $display("FAIL R1: unexpected done actual=1 expected=0");
            end else begin
               for (int c = 0; c < NCH; c++) begin
                  chk("R2", "dc", longint'($signed(dc_bus[c*W +: W])), pe_dc[c]);
                  chk("R3", "rms", longint'(rms_bus[c*W +: W]), pe_rms[c]);
                  he_dc[c] = pe_dc[c];
                  he_rms[c] = pe_rms[c];
               end
               for (int p = 0; p < NPAIR; p++) begin
                  chk(pe_ac ? "R6" : "R4", "real", longint'($signed(pwr_p_bus[p*PW +: PW])), pe_p[p]);
                  chk(pe_ac ? "R6" : "R5", "reactive", longint'($signed(pwr_q_bus[p*PW +: PW])), pe_q[p]);
                  he_p[p] = pe_p[p];
                  he_q[p] = pe_q[p];
               end
               chk("R7", "valid", longint'(res_valid), longint'(pe_valid));
               he_valid = pe_valid;
               pending = 0;
               dones++;
            end
         end else begin
            for (int c = 0; c < NCH; c++) begin
               chk("R8", "dc hold", longint'($signed(dc_bus[c*W +: W])), he_dc[c]);
               chk("R8", "rms hold", longint'(rms_bus[c*W +: W]), he_rms[c]);
            end
            for (int p = 0; p < NPAIR; p++) begin
               chk("R8", "real hold", longint'($signed(pwr_p_bus[p*PW +: PW])), he_p[p]);
               chk("R8", "reactive hold", longint'($signed(pwr_q_bus[p*PW +: PW])), he_q[p]);
            end
            chk("R8", "valid hold", longint'(res_valid), longint'(he_valid));
         end
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         misses++;
         $display("FAIL watchdog: run hung actual=0 expected=1");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   initial begin
      int v [NCH];
      int lcg = 32'h1234_5678;
      for (int c = 0; c < NCH; c++) begin
         he_dc[c] = 0;
         he_rms[c] = 0;
      end
      for (int p = 0; p < NPAIR; p++) begin
         he_p[p] = 0;
         he_q[p] = 0;
      end
      rst_n = 1'b0; smp_stb = 1'b0; smp_bus = '0; long_cyc = 1'b0; dc_strip = 1'b0;
      // pairs: (v0,i1) (v2,i3) (v4,i5)
      pair_sel = {3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk("R10", "done", longint'(res_done), 0);
      chk("R10", "valid", longint'(res_valid), 0);
      chk("R10", "overrun", longint'(overrun), 0);
      chk("R10", "dc bus zero", longint'(dc_bus == '0), 1);
      chk("R10", "rms bus zero", longint'(rms_bus == '0), 1);
      chk("R10", "power zero", longint'(pwr_p_bus == '0 && pwr_q_bus == '0), 1);
      checking = 1;

      // phase A: N=64, no DC removal, pseudo-random samples with offsets
      for (int k = 0; k < 3*64; k++) begin
         for (int c = 0; c < NCH; c++) begin
            lcg = lcg * 1103515245 + 12345;
            v[c] = ((lcg >> 8) % 20001) - 10000 + c*1000;
         end
         strobe(v);
      end

      // phase B: N=128 (restart), DC removal, extremes and sinusoids
      long_cyc = 1'b1;
      dc_strip = 1'b1;
      // pairs: (v3,i4) (v5,i6) (v7,i0)
      pair_sel = {3'd0, 3'd7, 3'd6, 3'd5, 3'd4, 3'd3};
      for (int k = 0; k < 2*128; k++) begin
         v[0] = -32768;
         v[1] = 32767;
         v[2] = (k % 2 == 1) ? -1 : 0;
         for (int c = 3; c < NCH; c++)
            v[c] = $rtoi(15000.0 * $sin(6.283185307 * k / 128.0 + c)) + c*700 - 2000;
         strobe(v);
      end

      // R1 done count
      chk("R1", "done count", longint'(dones), 5);

      // R9 overrun: second strobe while the sequencer is busy
      chk("R9", "overrun before", longint'(overrun), 0);
      @(negedge clk);
      smp_stb = 1'b1;
      @(negedge clk);
      smp_stb = 1'b0;
      repeat (4) @(negedge clk);
      smp_stb = 1'b1;
      @(negedge clk);
      smp_stb = 1'b0;
      @(negedge clk);
      chk("R9", "overrun set", longint'(overrun), 1);
      repeat (300) @(negedge clk);
      chk("R9", "overrun sticky", longint'(overrun), 1);
      chk("R9", "no extra done", longint'(dones), 5);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule